// File: doc/BRIEF.md
# SPI Status Poll Unit

This block interrogates an external device over SPI until the device reports that it is idle and, optionally, that further status flags are set. A single start pulse together with an 8-bit mask begins a poll run. Each status read consists of two one-byte transfers that send the status opcode. Chip select is raised between the two transfers, and only the reply to the second transfer is evaluated. The reply to the first transfer is discarded because it may be stale.

Each evaluated status byte ends the run in one of three ways. Either of the two protocol-fault bits ends the run with an error, and this takes precedence over every other outcome. A match of the mask with the busy bit clear ends the run successfully. If the poll window has elapsed, the run ends with a timeout. Otherwise the next read follows straight away, after the minimum chip-select high time. The window is a cycle count derived from the clock frequency and a duration in milliseconds. The final status byte, a one-cycle completion pulse and the error and timeout flags are presented to the surrounding logic. A sub-unit that is reused elsewhere shifts the bits of each byte on the SPI pins.

Top module: `spi_status_poller`

## Requirements
- R1: After reset, cs_no is high, sclk_o is low, and done_o, error_o and timeout_o are low.
- R2: A status read is two one-byte SPI transfers in mode 0. Each transfer sends opcode 0x00 most significant bit first, with 8 rising SCLK edges. The reply of the first transfer is discarded and the reply of the second is evaluated. sclk_o stays low while cs_no is high.
- R3: Between any two transfers of a run, cs_no stays high for at least 2*CLK_DIV clock cycles.
- R4: Let s be the evaluated byte and m the latched mask. If bit 3 and bit 2 of s are both clear and (s & (8'h01 | m)) == m, the run ends with done_o, error_o low and status_o = s. Bit 0 of s is busy and bit 1 is ready.
- R5: If bit 2 (protocol violation) or bit 3 (protocol error) of the evaluated byte is set, the run ends with error_o high and status_o equal to that byte, even when the mask condition also holds.
- R6: When none of the end conditions holds, a new status read is started immediately, and polling continues until an end condition is met.
- R7: Let the poll window be CLK_HZ/1000*TIMEOUT_MS cycles from the start pulse. A failing evaluation made once the window has elapsed ends the run with timeout_o high, error_o low and status_o equal to the last evaluated byte. error_o and timeout_o are never high together.
- R8: done_o is a single-cycle pulse. status_o, error_o and timeout_o hold their values after it until the next accepted start.
- R9: start_i is ignored while a run is in progress, and the mask is latched when start_i is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a poll run |
| mask_i | input | 8 | Status bits required to be set for success |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to device |
| miso_i | input | 1 | SPI data from device |
| status_o | output | 8 | Last evaluated status byte |
| done_o | output | 1 | One-cycle pulse when a run ends |
| error_o | output | 1 | Run ended on a protocol fault bit |
| timeout_o | output | 1 | Run ended because the poll window elapsed |

## Verification
The bench builds the block with CLK_DIV=2, CLK_HZ=1_000_000 and TIMEOUT_MS=1. This gives a 1000-cycle poll window, so a timeout run finishes after about a dozen status reads instead of the hundreds of millions of cycles that the default values imply. With the short SCLK divider, every read takes about eighty cycles. Multi-read success sequences, error bits that override a matching mask, and a restart attempt in the middle of a run therefore all fit easily within the run budget. The device model answers the first transfer of every pair with a byte that has both fault bits set. Any use of the discarded reply would therefore show up as a false error.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;
  localparam logic [7:0] STATUS_OPCODE = 8'h00;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_READY = 1;
  localparam int BIT_VIOL  = 2;
  localparam int BIT_FAULT = 3;

  typedef enum logic [1:0] {
    S_IDLE,
    S_XFER,
    S_GAP,
    S_REST
  } poll_state_e;
endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active_q, sclk_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          div_q    <= '0;
          bit_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};  // sample on rising edge
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};   // launch on falling edge
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = active_q & tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  assert_idle_clk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_q);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CNT_MAX);

  assert_expiry_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i) |=> expired_o);
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller
  import spi_poll_pkg::*;
#(
  parameter int          CLK_DIV    = 2,
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned TIMEOUT_MS = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic [7:0] status_o,
  output logic       done_o,
  output logic       error_o,
  output logic       timeout_o
);
  localparam int unsigned LIMIT = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int CSH   = 2 * CLK_DIV;
  localparam int GAP_W = $clog2(CSH + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CSH - 1);

  poll_state_e      st_q;
  logic             second_q, cs_q, go_q, done_q, err_q, to_q;
  logic [GAP_W-1:0] gap_q;
  logic [7:0]       mask_q, status_q;
  logic [7:0]       sh_rx;
  logic             sh_done, expired, accept;
  logic             fault, match;

  assign accept = (st_q == S_IDLE) && start_i;

  spi_byte_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .tx_i   (STATUS_OPCODE),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (sh_rx),
    .done_o (sh_done)
  );

  poll_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .expired_o (expired)
  );

  assign fault = sh_rx[BIT_VIOL] | sh_rx[BIT_FAULT];
  assign match = (sh_rx & (8'(1 << BIT_BUSY) | mask_q)) == mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      second_q <= 1'b0;
      cs_q     <= 1'b1;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      to_q     <= 1'b0;
      gap_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      go_q   <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mask_q   <= mask_i;
          err_q    <= 1'b0;
          to_q     <= 1'b0;
          second_q <= 1'b0;
          cs_q     <= 1'b0;
          go_q     <= 1'b1;
          st_q     <= S_XFER;
        end
        S_XFER: if (sh_done) begin
          cs_q  <= 1'b1;
          gap_q <= '0;
          if (!second_q) begin
            second_q <= 1'b1;
            st_q     <= S_GAP;
          end else if (fault || match || expired) begin
            status_q <= sh_rx;
            done_q   <= 1'b1;
            err_q    <= fault;
            to_q     <= !fault && !match;
            st_q     <= S_REST;
          end else begin
            second_q <= 1'b0;
            st_q     <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_q == GAP_LAST) begin
            cs_q <= 1'b0;
            go_q <= 1'b1;
            st_q <= S_XFER;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        S_REST: begin
          // hold chip select high before a new run may start
          if (gap_q == GAP_LAST) st_q <= S_IDLE;
          else                   gap_q <= gap_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_q;
  assign status_o  = status_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
  assign timeout_o = to_q;

  // chip-select high-time monitor
  logic [GAP_W-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_cnt_q <= GAP_W'(CSH);
    else if (!cs_no)   hi_cnt_q <= '0;
    else if (hi_cnt_q != GAP_W'(CSH)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_cs_high_time_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt_q == GAP_W'(CSH)));

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_reported_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && error_o) |-> (status_o[BIT_VIOL] || status_o[BIT_FAULT]));

  assert_success_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o && !timeout_o) |->
      ((status_o & (8'(1 << BIT_BUSY) | mask_q)) == mask_q));

  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(error_o && timeout_o));

  assert_mask_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |=> $stable(mask_q));
endmodule

// File: tb/sim_spi_status_poller.sv
module sim_spi_status_poller;
  localparam int CLK_DIV = 2;
  localparam int CSH     = 2 * CLK_DIV;
  localparam int LIMIT   = 1000;
  localparam logic [7:0] JUNK = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] mask = '0;
  logic sclk, cs_n, mosi, miso = 1'b0;
  logic [7:0] status;
  logic done, error, tmo;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  spi_status_poller #(.CLK_DIV(CLK_DIV), .CLK_HZ(1_000_000), .TIMEOUT_MS(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mask_i(mask),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso),
    .status_o(status), .done_o(done), .error_o(error), .timeout_o(tmo));

  // device model
  logic [7:0] script [0:15];
  int script_len = 1;
  int xfer_cnt = 0, bad_xfer = 0, nbits = 0, hi_cnt = 0, min_gap = 1000;
  bit run_active = 1'b0;
  logic [7:0] dev_sh, mosi_sh;

  always @(negedge cs_n) begin
    logic [7:0] r;
    int k;
    if (run_active && xfer_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
    k = xfer_cnt / 2;
    if (k > script_len - 1) k = script_len - 1;
    r = (xfer_cnt % 2 == 0) ? JUNK : script[k];
    miso = r[7];
    dev_sh = {r[6:0], 1'b0};
    mosi_sh = '0;
    nbits = 0;
  end
  always @(negedge sclk) if (!cs_n) begin
    miso = dev_sh[7];
    dev_sh = {dev_sh[6:0], 1'b0};
  end
  always @(posedge sclk) begin
    mosi_sh = {mosi_sh[6:0], mosi};
    nbits++;
    if (cs_n) bad_xfer++;
  end
  always @(posedge cs_n) if (run_active) begin
    if (nbits != 8 || mosi_sh != 8'h00) bad_xfer++;
    xfer_cnt++;
  end
  always @(posedge clk) hi_cnt = cs_n ? hi_cnt + 1 : 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // start a run; optionally pulse start again at cycle poke_at
  task automatic run(input logic [7:0] m, input int poke_at, output int cyc);
    xfer_cnt = 0; bad_xfer = 0; min_gap = 1000; run_active = 1'b1;
    @(negedge clk); start = 1'b1; mask = m;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (cyc == poke_at) begin start = 1'b1; mask = 8'h02; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    check(done === 1'b1, "R6", "run completed", cyc, 0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done single cycle", done, 0);
    repeat (10) @(negedge clk);
    run_active = 1'b0;
  endtask

  task automatic t_reset;
    check(cs_n === 1'b1, "R1", "cs_no idle", cs_n, 1);
    check(sclk === 1'b0, "R1", "sclk idle", sclk, 0);
    check({done, error, tmo} === 3'b000, "R1", "flags clear", {done, error, tmo}, 0);
  endtask

  task automatic t_immediate;
    int c;
    script[0] = 8'h00; script_len = 1;
    run(8'h00, -1, c);
    check(status === 8'h00, "R2", "second reply kept", status, 0);
    check(error === 1'b0, "R2", "junk first reply ignored", error, 0);
    check(xfer_cnt == 2, "R2", "transfers per read", xfer_cnt, 2);
    check(bad_xfer == 0, "R2", "opcode/bit count", bad_xfer, 0);
  endtask

  task automatic t_busy_then_clear;
    int c;
    script[0] = 8'h01; script[1] = 8'h01; script[2] = 8'h00; script_len = 3;
    run(8'h00, 100, c);
    check(status === 8'h00 && !error && !tmo, "R6", "ends after busy clears", status, 0);
    check(xfer_cnt == 6, "R9", "mid-run start ignored", xfer_cnt, 6);
    check(min_gap == CSH, "R3", "cs high time", min_gap, CSH);
    check(status === 8'h00, "R8", "status held", status, 0);
  endtask

  task automatic t_ready_mask;
    int c;
    script[0] = 8'h00; script[1] = 8'h01; script[2] = 8'h03; script[3] = 8'h02;
    script_len = 4;
    run(8'h02, -1, c);
    check(status === 8'h02 && !error && !tmo, "R4", "ready with busy clear", status, 2);
    check(xfer_cnt == 8, "R4", "reads until match", xfer_cnt, 8);
  endtask

  task automatic t_errors;
    int c;
    script[0] = 8'h01; script[1] = 8'h05; script_len = 2;
    run(8'h02, -1, c);
    check(error === 1'b1 && tmo === 1'b0, "R5", "violation bit", error, 1);
    check(status === 8'h05, "R5", "violation status", status, 5);
    script[0] = 8'h08; script_len = 1;
    run(8'h00, -1, c);
    check(error === 1'b1, "R5", "fault overrides match", error, 1);
    check(xfer_cnt == 2, "R5", "stops at once", xfer_cnt, 2);
    check(error === 1'b1, "R8", "error held", error, 1);
  endtask

  task automatic t_timeout;
    int c;
    script[0] = 8'h01; script_len = 1;
    run(8'h00, -1, c);
    check(tmo === 1'b1 && error === 1'b0, "R7", "timeout flag", tmo, 1);
    check(status === 8'h01, "R7", "last status", status, 1);
    check(c >= LIMIT && c <= LIMIT + 100, "R7", "timeout window", c, LIMIT);
    check(bad_xfer == 0, "R2", "opcode across many reads", bad_xfer, 0);
    script[0] = 8'h00;
    run(8'h00, -1, c);
    check(tmo === 1'b0 && error === 1'b0, "R8", "flags cleared by new start", tmo, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_immediate;
    t_busy_then_clear;
    t_ready_mask;
    t_errors;
    t_timeout;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule